// File: doc/BRIEF.md
# CAN Identifier Screener and Error Injector

This block sits behind a bit-timing unit on a CAN bus tap. It takes the sampled receive bit with two strobes: one marking each bit boundary and one marking the sample point. It finds the start of a frame after bus idle and removes stuff bits. It then walks the first fifteen field bits of the frame: the 11-bit identifier, the RTR bit, two reserved bits and the top bit of the length code. The identifier and RTR bit are compared on the fly against a programmed target.

When the target frame is recognised and the block is enabled, the block drives an active error flag onto the bus. The flag is six dominant bit times, and it starts at the bit boundary right after the last screened bit. The frame still on the wire is therefore corrupted long before it could complete, and any other frame is left untouched. The transmit output is an active-low dominant drive, so it is 0 while the flag is driven and 1 otherwise. A one-cycle pulse and a wrapping counter report each injection.

Top module: `frame_screen_inject`

## Requirements
- R1: After reset `tx_n` is 1, `inject_pulse` is 0 and `match_count` is 0.
- R2: A dominant sampled bit counts as start of frame only after at least 11 consecutive recessive (1) sampled bits. Any frame seen earlier is ignored and is never injected.
- R3: Counting from the start-of-frame bit, after five consecutive equal bits the next sampled bit is a stuff bit. It is discarded and does not count as a field bit.
- R4: A sixth equal bit in the stuff position, before the fifteenth field bit, aborts screening, and that frame gets no flag.
- R5: The identifier arrives most significant bit first in field bits 1 to 11, and RTR is field bit 12. A match needs all twelve to equal `cfg_target_id` and `cfg_target_rtr`. Field bits 13 to 15 are received but not compared.
- R6: On a match, `tx_n` falls on the clock after the first `bit_edge` that follows the sample of field bit 15. That bit time is the one right after the field-15 bit on the wire.
- R7: The flag holds `tx_n` at 0 for exactly six bit-boundary intervals, and then `tx_n` returns to 1.
- R8: A frame whose identifier or RTR differs from the target leaves `tx_n` at 1 for the whole frame.
- R9: If `cfg_enable` is 0 when field bit 15 is sampled, no flag is driven and `match_count` does not change.
- R10: Each injection raises `inject_pulse` for one cycle, in the same cycle that `tx_n` falls, and adds 1 (wrapping) to `match_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_edge | input | 1 | One-cycle strobe at each bit boundary |
| sample_tick | input | 1 | One-cycle strobe at each sample point |
| rx_bit | input | 1 | Sampled bus level (0 = dominant) |
| cfg_enable | input | 1 | Allows arming on a match |
| cfg_target_id | input | ID_W | Identifier to screen for |
| cfg_target_rtr | input | 1 | RTR value to screen for |
| tx_n | output | 1 | Active-low dominant drive to the transmitter |
| inject_pulse | output | 1 | One-cycle pulse when a flag starts |
| match_count | output | CNT_W | Count of injections, wrapping |

## Verification
The match decision is registered at the sample strobe of field bit 15. `tx_n` then changes one clock after the next `bit_edge`, and each later change of `tx_n` is also one clock after a `bit_edge`. The bench drives each bit as eight clocks, with `bit_edge` in the first clock and `sample_tick` in the fourth. It reads `tx_n` at the falling clock edge after the sample strobe, by which time the level for that bit time has settled. Per frame, the bench checks which wire bit carries the first dominant flag bit and how many bits are dominant. `match_count` is checked only after the frame's recessive tail, long after any update.

// File: rtl/frame_screen_pkg.sv
package frame_screen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE_WAIT,
    ST_HUNT,
    ST_SCREEN,
    ST_INJECT
  } scr_state_t;
endpackage

// File: rtl/bit_destuffer.sv
// Removes stuff bits from the in-frame bit stream and flags stuffing violations.
module bit_destuffer #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,     // start-of-frame bit sampled (dominant)
  input  logic sample,    // in-frame sample strobe
  input  logic bit_in,
  output logic dv,        // bit_in is a field bit
  output logic dbit,
  output logic serr       // sixth equal bit
);
  localparam int RW = $clog2(RUN + 1);

  logic          last_q;
  logic [RW-1:0] run_q;
  logic          is_stuff;

  assign is_stuff = (run_q == RW'(RUN));

  always_comb begin
    dv   = sample && !is_stuff;
    dbit = bit_in;
    serr = sample && is_stuff && (bit_in == last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else if (start) begin
      last_q <= 1'b0;
      run_q  <= RW'(1);
    end else if (sample) begin
      if (is_stuff || (bit_in != last_q)) begin
        last_q <= bit_in;
        run_q  <= RW'(1);
      end else begin
        run_q  <= run_q + RW'(1);
      end
    end
  end
endmodule

// File: rtl/hdr_screen.sv
// Counts destuffed header bits and compares identifier and RTR on the fly.
module hdr_screen #(
  parameter int ID_W     = 11,
  parameter int HDR_BITS = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            dv,
  input  logic            dbit,
  input  logic [ID_W-1:0] tid,
  input  logic            trtr,
  output logic            done,
  output logic            hit
);
  localparam int CW = $clog2(HDR_BITS + 1);

  logic [CW-1:0] cnt_q;
  logic          miss_q;
  logic          exp_bit;
  logic          cmp_en;

  always_comb begin
    exp_bit = trtr;
    for (int i = 0; i < ID_W; i++) begin
      if (cnt_q == CW'(i)) exp_bit = tid[ID_W-1-i];
    end
  end

  assign cmp_en = dv && (cnt_q <= CW'(ID_W));
  assign done   = dv && (cnt_q == CW'(HDR_BITS - 1));
  assign hit    = !miss_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (dv) begin
      cnt_q  <= cnt_q + CW'(1);
      if (cmp_en && (dbit != exp_bit)) miss_q <= 1'b1;
    end
  end
endmodule

// File: rtl/err_flag_drv.sv
// Waits for a bit boundary once armed, then drives FLAG_BITS dominant bit times.
module err_flag_drv #(
  parameter int FLAG_BITS = 6,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             bit_edge,
  output logic             tx_n,
  output logic             inject_pulse,
  output logic             done,
  output logic [CNT_W-1:0] match_count
);
  localparam int FW = $clog2(FLAG_BITS + 1);

  logic          armed_q;
  logic          active_q;
  logic [FW-1:0] fcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q      <= 1'b0;
      active_q     <= 1'b0;
      fcnt_q       <= '0;
      tx_n         <= 1'b1;
      inject_pulse <= 1'b0;
      done         <= 1'b0;
      match_count  <= '0;
    end else begin
      inject_pulse <= 1'b0;
      done         <= 1'b0;
      if (arm) armed_q <= 1'b1;
      if (armed_q && bit_edge) begin
        armed_q      <= 1'b0;
        active_q     <= 1'b1;
        fcnt_q       <= '0;
        tx_n         <= 1'b0;
        inject_pulse <= 1'b1;
        match_count  <= match_count + CNT_W'(1);
      end else if (active_q && bit_edge) begin
        if (fcnt_q == FW'(FLAG_BITS - 1)) begin
          active_q <= 1'b0;
          tx_n     <= 1'b1;
          done     <= 1'b1;
        end else begin
          fcnt_q <= fcnt_q + FW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/frame_screen_inject.sv
module frame_screen_inject
  import frame_screen_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int RSV_BITS  = 2,
  parameter int STUFF_RUN = 5,
  parameter int IDLE_BITS = 11,
  parameter int FLAG_BITS = 6,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_edge,
  input  logic             sample_tick,
  input  logic             rx_bit,
  input  logic             cfg_enable,
  input  logic [ID_W-1:0]  cfg_target_id,
  input  logic             cfg_target_rtr,
  output logic             tx_n,
  output logic             inject_pulse,
  output logic [CNT_W-1:0] match_count
);
  localparam int HDR_BITS = ID_W + 1 + RSV_BITS + 1;
  localparam int IW       = $clog2(IDLE_BITS + 1);

  scr_state_t    st_q;
  logic [IW-1:0] idle_q;
  logic          sof, ds_sample, dv, dbit, serr, hdr_done, hdr_hit, arm, flag_done;

  assign sof       = (st_q == ST_HUNT) && sample_tick && !rx_bit;
  assign ds_sample = (st_q == ST_SCREEN) && sample_tick;
  assign arm       = (st_q == ST_SCREEN) && !serr && hdr_done && hdr_hit && cfg_enable;

  bit_destuffer #(.RUN(STUFF_RUN)) u_dstf (
    .clk(clk), .rst(rst), .start(sof), .sample(ds_sample), .bit_in(rx_bit),
    .dv(dv), .dbit(dbit), .serr(serr)
  );

  hdr_screen #(.ID_W(ID_W), .HDR_BITS(HDR_BITS)) u_hdr (
    .clk(clk), .rst(rst), .clear(sof), .dv(dv), .dbit(dbit),
    .tid(cfg_target_id), .trtr(cfg_target_rtr), .done(hdr_done), .hit(hdr_hit)
  );

  err_flag_drv #(.FLAG_BITS(FLAG_BITS), .CNT_W(CNT_W)) u_flag (
    .clk(clk), .rst(rst), .arm(arm), .bit_edge(bit_edge), .tx_n(tx_n),
    .inject_pulse(inject_pulse), .done(flag_done), .match_count(match_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE_WAIT;
      idle_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE_WAIT: if (sample_tick) begin
          if (!rx_bit) begin
            idle_q <= '0;
          end else if (idle_q == IW'(IDLE_BITS - 1)) begin
            idle_q <= '0;
            st_q   <= ST_HUNT;
          end else begin
            idle_q <= idle_q + IW'(1);
          end
        end
        ST_HUNT: if (sof) st_q <= ST_SCREEN;
        ST_SCREEN: begin
          if (serr) st_q <= ST_IDLE_WAIT;
          else if (hdr_done) st_q <= arm ? ST_INJECT : ST_IDLE_WAIT;
        end
        ST_INJECT: if (flag_done) st_q <= ST_IDLE_WAIT;
        default: st_q <= ST_IDLE_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/screen_inject_chk.sv
module screen_inject_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_edge,
  input logic             tx_n,
  input logic             inject_pulse,
  input logic [CNT_W-1:0] match_count
);
  logic [3:0] low_edges;
  always_ff @(posedge clk) begin
    if (rst || tx_n) low_edges <= '0;
    else if (bit_edge) low_edges <= low_edges + 4'd1;
  end

  // R6
  flag_start_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_n) |-> $past(bit_edge));
  // R7
  flag_end_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_n) |-> $past(bit_edge));
  // R7
  flag_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_n) |-> (low_edges == 4'd6));
  // R10
  pulse_with_fall_chk: assert property (@(posedge clk) disable iff (rst)
    inject_pulse |-> $fell(tx_n));
  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(match_count) |-> (match_count == $past(match_count) + CNT_W'(1)) && inject_pulse);
endmodule

bind frame_screen_inject screen_inject_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_edge(bit_edge), .tx_n(tx_n),
  .inject_pulse(inject_pulse), .match_count(match_count)
);

// File: tb/sim_frame_screen_inject.sv
`timescale 1ns/1ps
module sim_frame_screen_inject;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_edge = 1'b0, sample_tick = 1'b0, rx_drv = 1'b1;
  logic        cfg_enable = 1'b0, cfg_target_rtr = 1'b0;
  logic [10:0] cfg_target_id = '0;
  logic        tx_n, inject_pulse, rx_bit;
  logic [7:0]  match_count;

  int checks = 0, fails = 0, exp_count = 0;
  logic fb [0:127];
  int flen, hdr_end_pos, low_cnt, first_low, last_low;

  always #2.5 clk = ~clk;
  assign rx_bit = rx_drv & tx_n;

  frame_screen_inject u0 (
    .clk(clk), .rst(rst), .bit_edge(bit_edge), .sample_tick(sample_tick),
    .rx_bit(rx_bit), .cfg_enable(cfg_enable), .cfg_target_id(cfg_target_id),
    .cfg_target_rtr(cfg_target_rtr), .tx_n(tx_n), .inject_pulse(inject_pulse),
    .match_count(match_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Builds the wire bits of a frame; SOF is field index 0, DLC MSB is index 15.
  task automatic build(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                       input logic [14:0] crc, input bit do_stuff);
    logic raw [0:33];
    logic last;
    int run;
    raw[0] = 1'b0;
    for (int i = 0; i < 11; i++) raw[1+i] = id[10-i];
    raw[12] = rtr; raw[13] = 1'b0; raw[14] = 1'b0;
    for (int i = 0; i < 4; i++) raw[15+i] = dlc[3-i];
    for (int i = 0; i < 15; i++) raw[19+i] = crc[14-i];
    flen = 0; run = 0; last = 1'b1;
    for (int i = 0; i < 34; i++) begin
      fb[flen] = raw[i];
      if (i == 15) hdr_end_pos = flen;
      flen++;
      if (raw[i] == last) run++;
      else begin last = raw[i]; run = 1; end
      if (do_stuff && run == 5) begin
        fb[flen] = !raw[i]; flen++; last = !raw[i]; run = 1;
      end
    end
    for (int i = 0; i < 22; i++) begin fb[flen] = 1'b1; flen++; end
  endtask

  task automatic send_bit(input logic b, input int idx);
    @(negedge clk); rx_drv = b; bit_edge = 1'b1;
    @(negedge clk); bit_edge = 1'b0;
    repeat (2) @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
    if (!tx_n) begin
      if (low_cnt == 0) first_low = idx;
      last_low = idx;
      low_cnt++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input bit expect_inj, input string tag);
    low_cnt = 0; first_low = -1; last_low = -1;
    for (int i = 0; i < flen; i++) send_bit(fb[i], i);
    if (expect_inj) begin
      exp_count = (exp_count + 1) % 256;
      chk(first_low == hdr_end_pos + 1, tag, first_low, hdr_end_pos + 1);
      chk(low_cnt == 6 && last_low - first_low == 5, "R7", low_cnt, 6);
    end else begin
      chk(low_cnt == 0, tag, low_cnt, 0);
    end
    chk(int'(match_count) == exp_count, "R10", int'(match_count), exp_count);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(tx_n == 1'b1, "R1", int'(tx_n), 1);
    chk(inject_pulse == 1'b0, "R1", int'(inject_pulse), 0);
    chk(match_count == 8'd0, "R1", int'(match_count), 0);

    // R2: matching frame after too short an idle is ignored
    cfg_enable = 1'b1; cfg_target_id = 11'h2A5; cfg_target_rtr = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1, -1);
    build(11'h2A5, 1'b0, 4'h8, 15'h1234, 1'b1);
    run_frame(1'b0, "R2");

    // R6 plain match
    build(11'h2A5, 1'b0, 4'h8, 15'h4321, 1'b1);
    run_frame(1'b1, "R6");
    // R8 last identifier bit differs
    build(11'h2A4, 1'b0, 4'h8, 15'h0F0F, 1'b1);
    run_frame(1'b0, "R8");
    // R5 RTR differs
    build(11'h2A5, 1'b1, 4'h0, 15'h0F0F, 1'b1);
    run_frame(1'b0, "R5");
    // R9 disabled
    cfg_enable = 1'b0;
    build(11'h2A5, 1'b0, 4'h8, 15'h0001, 1'b1);
    run_frame(1'b0, "R9");
    cfg_enable = 1'b1;
    // R3 all-zero identifier: several stuff bits in the header
    cfg_target_id = 11'h000; cfg_target_rtr = 1'b0;
    build(11'h000, 1'b0, 4'h0, 15'h7FFF, 1'b1);
    run_frame(1'b1, "R3");
    // R3 all-one identifier with RTR set
    cfg_target_id = 11'h7FF; cfg_target_rtr = 1'b1;
    build(11'h7FF, 1'b1, 4'hF, 15'h0000, 1'b1);
    run_frame(1'b1, "R3");
    // R4 missing stuff bit aborts screening
    cfg_target_id = 11'h000; cfg_target_rtr = 1'b0;
    build(11'h000, 1'b0, 4'h0, 15'h5555, 1'b0);
    run_frame(1'b0, "R4");

    // Random frames (R5 R6 R8 R9)
    for (int n = 0; n < 40; n++) begin
      logic [10:0] id;
      logic rtr;
      bit exp;
      id = 11'($urandom); rtr = 1'($urandom);
      cfg_target_id = ($urandom % 2) ? id : 11'($urandom);
      cfg_target_rtr = ($urandom % 4 == 0) ? !rtr : rtr;
      cfg_enable = ($urandom % 10) != 0;
      exp = cfg_enable && cfg_target_id == id && cfg_target_rtr == rtr;
      build(id, rtr, 4'($urandom), 15'($urandom), 1'b1);
      run_frame(exp, exp ? "R6" : "R8");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule